// File: doc/BRIEF.md
# Register Rename Stage with Branch Checkpoints

This block sits between decode and the issue queue of an out-of-order core. Each cycle it takes a group of up to `WIDTH` instructions. Each instruction names two logical source registers and one logical destination. The block turns each source into a physical tag by looking it up in a speculative map. It gives each destination a fresh physical register taken from a circular free pool. It also reports the physical register that the destination was bound to before renaming. The reorder buffer holds that previous binding until the instruction retires.

A source can name the destination of an earlier instruction in the same group. In that case the source takes the earlier instruction's new physical register, not the map value. A retire port updates a committed (architectural) map and hands each retired instruction's previous binding back to the pool. A branch can save a checkpoint of the speculative map together with the pool's read pointer. A recovery request restores both.

Top module: `reg_rename`

## Requirements
- R1: After reset, logical register i maps to physical register i in both the speculative and the committed map. The pool holds the registers NUM_LOG to NUM_PHYS-1 in ascending order.
- R2: With no same-group override, a source's physical tag is the speculative map entry of its logical register, seen combinationally in the same cycle.
- R3: Each valid slot, taken in slot order (slot 0 first), receives the next register at the pool head. The new binding is written into the speculative map at the clock edge. No two slots get the same register, and none gets a register that is still in the speculative map.
- R4: A source of slot j whose logical register equals the destination of a valid slot i < j takes slot i's new physical register. The youngest such earlier slot wins.
- R5: The old-destination output of a slot is the binding before renaming. If an earlier valid slot in the group writes the same logical register, it is that slot's new register. The map keeps the youngest slot's binding.
- R6: Ready is low when the pool holds fewer registers than the number of valid slots. While ready is low, the map and the pool are not changed.
- R7: Each valid retire slot writes its physical destination into the committed map. For the same logical register in one cycle, the higher retire slot wins.
- R8: Each valid retire slot appends its old physical destination to the pool tail, in slot order. Freed registers are handed out after those already in the pool.
- R9: A checkpoint save stores the speculative map as it stands after that cycle's group, together with the pool head after that group's allocation. Recovery restores both from the selected checkpoint at the next edge. Registers allocated since the save become free again. Ready is low in the recovery cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ren_valid_i | input | WIDTH | Per-slot valid of the rename group |
| ren_src1_i | input | WIDTH x LW | First logical source per slot |
| ren_src2_i | input | WIDTH x LW | Second logical source per slot |
| ren_dst_i | input | WIDTH x LW | Logical destination per slot |
| ren_ready_o | output | 1 | Group accepted this cycle |
| ren_psrc1_o | output | WIDTH x PW | First physical source per slot |
| ren_psrc2_o | output | WIDTH x PW | Second physical source per slot |
| ren_pdst_o | output | WIDTH x PW | New physical destination per slot |
| ren_old_pdst_o | output | WIDTH x PW | Previous binding of the destination per slot |
| ckpt_save_i | input | 1 | Save a checkpoint after this cycle's group |
| ckpt_save_id_i | input | KW | Checkpoint slot to write |
| recover_i | input | 1 | Restore a checkpoint |
| recover_id_i | input | KW | Checkpoint slot to restore |
| cmt_valid_i | input | WIDTH | Per-slot retire valid |
| cmt_dst_i | input | WIDTH x LW | Logical destination of the retiring instruction |
| cmt_pdst_i | input | WIDTH x PW | Physical destination of the retiring instruction |
| cmt_old_pdst_i | input | WIDTH x PW | Previous binding to free |
| arch_map_o | output | NUM_LOG x PW | Committed map, entry i for logical register i |

## Verification
The bench builds the block with its defaults: 6 logical and 10 physical registers, a group of 2 and 2 checkpoints. With only four registers free at reset, a few groups drain the pool. Stalls with one and with zero registers left therefore come up quickly. The same pool slots are refilled by retirement and then handed out again after a recovery rewinds the head. The sequence also sets up same-group source overrides, a same-group double write to one logical register, and a retire cycle in which both slots name the same logical register.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int unsigned DEF_LOG   = 6;
  localparam int unsigned DEF_PHYS  = 10;
  localparam int unsigned DEF_WIDTH = 2;
  localparam int unsigned DEF_CKPT  = 2;
endpackage

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int unsigned DEPTH     = 10,
  parameter int unsigned WIDTH     = 2,
  parameter int unsigned PW        = 4,
  parameter int unsigned INIT_BASE = 6,
  parameter int unsigned INIT_CNT  = 4,
  localparam int unsigned IW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1),
  localparam int unsigned NW = $clog2(WIDTH + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NW-1:0]             pop_cnt_i,
  output logic [WIDTH-1:0][PW-1:0]  pop_pd_o,
  output logic [CW-1:0]             free_cnt_o,
  output logic [IW:0]               head_nxt_o,
  input  logic [WIDTH-1:0]          push_i,
  input  logic [WIDTH-1:0][PW-1:0]  push_pd_i,
  input  logic                      restore_i,
  input  logic [IW:0]               restore_head_i
);
  logic [DEPTH-1:0][PW-1:0] mem_q;
  logic [IW:0] head_q, tail_q;
  logic [WIDTH-1:0][IW:0] pop_ptr, push_ptr;
  logic [NW-1:0] push_cnt;

  // pointer = {wrap, index}; index wraps at DEPTH
  function automatic logic [IW:0] adv(input logic [IW:0] p, input int unsigned k);
    logic [IW:0] r;
    r = p;
    for (int unsigned i = 0; i < WIDTH; i++) begin
      if (i < k) begin
        if (r[IW-1:0] == IW'(DEPTH - 1)) r = {~r[IW], {IW{1'b0}}};
        else r = r + 1'b1;
      end
    end
    return r;
  endfunction

  always_comb begin
    int unsigned pc;
    pc = 0;
    for (int unsigned j = 0; j < WIDTH; j++) begin
      pop_ptr[j]  = adv(head_q, j);
      pop_pd_o[j] = mem_q[pop_ptr[j][IW-1:0]];
      push_ptr[j] = adv(tail_q, pc);
      if (push_i[j]) pc = pc + 1;
    end
    push_cnt   = NW'(pc);
    head_nxt_o = adv(head_q, int'(pop_cnt_i));
  end

  always_comb begin
    int unsigned c;
    if (head_q[IW] == tail_q[IW]) c = int'(tail_q[IW-1:0]) - int'(head_q[IW-1:0]);
    else c = DEPTH - int'(head_q[IW-1:0]) + int'(tail_q[IW-1:0]);
    free_cnt_o = CW'(c);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int unsigned i = 0; i < DEPTH; i++)
        mem_q[i] <= (i < INIT_CNT) ? PW'(INIT_BASE + i) : '0;
      head_q <= '0;
      tail_q <= {1'b0, IW'(INIT_CNT)};
    end else begin
      for (int unsigned j = 0; j < WIDTH; j++)
        if (push_i[j]) mem_q[push_ptr[j][IW-1:0]] <= push_pd_i[j];
      tail_q <= adv(tail_q, int'(push_cnt));
      head_q <= restore_i ? restore_head_i : head_nxt_o;
    end
  end

  a_r6_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(pop_cnt_i) <= int'(free_cnt_o));
  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(free_cnt_o) <= DEPTH);
  a_r8_count_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restore_i |=> int'(free_cnt_o) ==
      int'($past(free_cnt_o)) - int'($past(pop_cnt_i)) + int'($past(push_cnt)));
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int unsigned NLOG  = 6,
  parameter int unsigned WIDTH = 2,
  parameter int unsigned PW    = 4,
  parameter int unsigned NCKPT = 2,
  parameter int unsigned HW    = 5,
  localparam int unsigned LW = $clog2(NLOG),
  localparam int unsigned KW = (NCKPT > 1) ? $clog2(NCKPT) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [WIDTH-1:0]         wr_en_i,
  input  logic [WIDTH-1:0][LW-1:0] wr_ld_i,
  input  logic [WIDTH-1:0][PW-1:0] wr_pd_i,
  input  logic                     save_i,
  input  logic [KW-1:0]            save_id_i,
  input  logic [HW-1:0]            save_head_i,
  input  logic                     restore_i,
  input  logic [KW-1:0]            restore_id_i,
  output logic [NLOG-1:0][PW-1:0]  map_o,
  output logic [HW-1:0]            ckpt_head_o
);
  logic [NLOG-1:0][PW-1:0] map_q, map_nxt, ckpt_sel;
  logic [NCKPT-1:0][NLOG-1:0][PW-1:0] ckpt_q;
  logic [NCKPT-1:0][HW-1:0] ckpt_head_q;

  // later slot overrides earlier one on same logical register
  always_comb begin
    map_nxt = map_q;
    for (int unsigned j = 0; j < WIDTH; j++)
      for (int unsigned i = 0; i < NLOG; i++)
        if (wr_en_i[j] && wr_ld_i[j] == LW'(i)) map_nxt[i] = wr_pd_i[j];
  end

  assign ckpt_sel    = ckpt_q[restore_id_i];
  assign ckpt_head_o = ckpt_head_q[restore_id_i];
  assign map_o       = map_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int unsigned i = 0; i < NLOG; i++) begin
        map_q[i] <= PW'(i);
        for (int unsigned k = 0; k < NCKPT; k++) ckpt_q[k][i] <= PW'(i);
      end
      ckpt_head_q <= '0;
    end else if (restore_i) begin
      map_q <= ckpt_sel;
    end else begin
      map_q <= map_nxt;
      if (save_i) begin
        ckpt_q[save_id_i]      <= map_nxt;
        ckpt_head_q[save_id_i] <= save_head_i;
      end
    end
  end

  a_r9_restore_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i |=> map_o == $past(ckpt_sel));
endmodule

// File: rtl/rn_dep_check.sv
module rn_dep_check #(
  parameter int unsigned NLOG  = 6,
  parameter int unsigned WIDTH = 2,
  parameter int unsigned PW    = 4,
  localparam int unsigned LW = $clog2(NLOG)
) (
  input  logic [NLOG-1:0][PW-1:0]  map_i,
  input  logic [WIDTH-1:0]         valid_i,
  input  logic [WIDTH-1:0][LW-1:0] ls1_i,
  input  logic [WIDTH-1:0][LW-1:0] ls2_i,
  input  logic [WIDTH-1:0][LW-1:0] ld_i,
  input  logic [WIDTH-1:0][PW-1:0] new_pd_i,
  output logic [WIDTH-1:0][PW-1:0] ps1_o,
  output logic [WIDTH-1:0][PW-1:0] ps2_o,
  output logic [WIDTH-1:0][PW-1:0] old_pd_o
);
  function automatic logic [PW-1:0] lookup(input logic [NLOG-1:0][PW-1:0] m,
                                           input logic [LW-1:0] lr);
    logic [PW-1:0] r;
    r = '0;
    for (int unsigned i = 0; i < NLOG; i++) if (lr == LW'(i)) r = m[i];
    return r;
  endfunction

  // youngest earlier slot wins: ascending loop, last match sticks
  always_comb begin
    for (int unsigned j = 0; j < WIDTH; j++) begin
      ps1_o[j]    = lookup(map_i, ls1_i[j]);
      ps2_o[j]    = lookup(map_i, ls2_i[j]);
      old_pd_o[j] = lookup(map_i, ld_i[j]);
      for (int unsigned i = 0; i < WIDTH; i++) begin
        if (i < j && valid_i[i]) begin
          if (ld_i[i] == ls1_i[j]) ps1_o[j]    = new_pd_i[i];
          if (ld_i[i] == ls2_i[j]) ps2_o[j]    = new_pd_i[i];
          if (ld_i[i] == ld_i[j])  old_pd_o[j] = new_pd_i[i];
        end
      end
    end
  end
endmodule

// File: rtl/reg_rename.sv
module reg_rename #(
  parameter int unsigned NUM_LOG  = rn_pkg::DEF_LOG,
  parameter int unsigned NUM_PHYS = rn_pkg::DEF_PHYS,
  parameter int unsigned WIDTH    = rn_pkg::DEF_WIDTH,
  parameter int unsigned NUM_CKPT = rn_pkg::DEF_CKPT,
  localparam int unsigned LW = $clog2(NUM_LOG),
  localparam int unsigned PW = $clog2(NUM_PHYS),
  localparam int unsigned IW = $clog2(NUM_PHYS),
  localparam int unsigned CW = $clog2(NUM_PHYS + 1),
  localparam int unsigned NW = $clog2(WIDTH + 1),
  localparam int unsigned KW = (NUM_CKPT > 1) ? $clog2(NUM_CKPT) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [WIDTH-1:0]           ren_valid_i,
  input  logic [WIDTH-1:0][LW-1:0]   ren_src1_i,
  input  logic [WIDTH-1:0][LW-1:0]   ren_src2_i,
  input  logic [WIDTH-1:0][LW-1:0]   ren_dst_i,
  output logic                       ren_ready_o,
  output logic [WIDTH-1:0][PW-1:0]   ren_psrc1_o,
  output logic [WIDTH-1:0][PW-1:0]   ren_psrc2_o,
  output logic [WIDTH-1:0][PW-1:0]   ren_pdst_o,
  output logic [WIDTH-1:0][PW-1:0]   ren_old_pdst_o,
  input  logic                       ckpt_save_i,
  input  logic [KW-1:0]              ckpt_save_id_i,
  input  logic                       recover_i,
  input  logic [KW-1:0]              recover_id_i,
  input  logic [WIDTH-1:0]           cmt_valid_i,
  input  logic [WIDTH-1:0][LW-1:0]   cmt_dst_i,
  input  logic [WIDTH-1:0][PW-1:0]   cmt_pdst_i,
  input  logic [WIDTH-1:0][PW-1:0]   cmt_old_pdst_i,
  output logic [NUM_LOG-1:0][PW-1:0] arch_map_o
);
  logic [NW-1:0] need;
  logic [WIDTH-1:0][NW-1:0] prefix;
  logic [CW-1:0] free_cnt;
  logic [IW:0] head_nxt, ckpt_head;
  logic [WIDTH-1:0][PW-1:0] pop_pd;
  logic [NUM_LOG-1:0][PW-1:0] spec_map;
  logic fire;
  logic [WIDTH-1:0] wr_en;
  logic [NUM_LOG-1:0][PW-1:0] arch_q;

  always_comb begin
    need = '0;
    for (int unsigned j = 0; j < WIDTH; j++) begin
      prefix[j] = need;
      need = need + NW'(ren_valid_i[j]);
    end
  end

  assign ren_ready_o = !recover_i && (int'(free_cnt) >= int'(need));
  assign fire        = ren_ready_o && |ren_valid_i;
  assign wr_en       = ren_valid_i & {WIDTH{fire}};

  always_comb begin
    for (int unsigned j = 0; j < WIDTH; j++) begin
      ren_pdst_o[j] = '0;
      for (int unsigned k = 0; k < WIDTH; k++)
        if (prefix[j] == NW'(k)) ren_pdst_o[j] = pop_pd[k];
    end
  end

  rn_free_list #(
    .DEPTH(NUM_PHYS), .WIDTH(WIDTH), .PW(PW),
    .INIT_BASE(NUM_LOG), .INIT_CNT(NUM_PHYS - NUM_LOG)
  ) i_free_list (
    .clk_i, .rst_ni,
    .pop_cnt_i(fire ? need : '0),
    .pop_pd_o(pop_pd),
    .free_cnt_o(free_cnt),
    .head_nxt_o(head_nxt),
    .push_i(cmt_valid_i),
    .push_pd_i(cmt_old_pdst_i),
    .restore_i(recover_i),
    .restore_head_i(ckpt_head)
  );

  rn_map_table #(
    .NLOG(NUM_LOG), .WIDTH(WIDTH), .PW(PW), .NCKPT(NUM_CKPT), .HW(IW + 1)
  ) i_map_table (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en),
    .wr_ld_i(ren_dst_i),
    .wr_pd_i(ren_pdst_o),
    .save_i(ckpt_save_i),
    .save_id_i(ckpt_save_id_i),
    .save_head_i(head_nxt),
    .restore_i(recover_i),
    .restore_id_i(recover_id_i),
    .map_o(spec_map),
    .ckpt_head_o(ckpt_head)
  );

  rn_dep_check #(.NLOG(NUM_LOG), .WIDTH(WIDTH), .PW(PW)) i_dep_check (
    .map_i(spec_map),
    .valid_i(ren_valid_i),
    .ls1_i(ren_src1_i),
    .ls2_i(ren_src2_i),
    .ld_i(ren_dst_i),
    .new_pd_i(ren_pdst_o),
    .ps1_o(ren_psrc1_o),
    .ps2_o(ren_psrc2_o),
    .old_pd_o(ren_old_pdst_o)
  );

  // committed map: higher retire slot wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int unsigned i = 0; i < NUM_LOG; i++) arch_q[i] <= PW'(i);
    end else begin
      for (int unsigned j = 0; j < WIDTH; j++)
        for (int unsigned i = 0; i < NUM_LOG; i++)
          if (cmt_valid_i[j] && cmt_dst_i[j] == LW'(i)) arch_q[i] <= cmt_pdst_i[j];
    end
  end
  assign arch_map_o = arch_q;

  logic dup_pd, stale_pd;
  always_comb begin
    dup_pd = 1'b0;
    stale_pd = 1'b0;
    for (int unsigned j = 0; j < WIDTH; j++) begin
      for (int unsigned i = 0; i < WIDTH; i++)
        if (i < j && wr_en[i] && wr_en[j] && ren_pdst_o[i] == ren_pdst_o[j]) dup_pd = 1'b1;
      for (int unsigned i = 0; i < NUM_LOG; i++)
        if (wr_en[j] && spec_map[i] == ren_pdst_o[j]) stale_pd = 1'b1;
    end
  end

  a_r3_distinct_pdst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |-> !dup_pd);
  a_r3_fresh_pdst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |-> !stale_pd);
  a_r9_no_rename_on_recover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recover_i |-> !fire);
endmodule

// File: tb/test_reg_rename.sv
module test_reg_rename;
  localparam int unsigned NL = 6, NP = 10, W = 2;
  localparam int unsigned LW = 3, PW = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [W-1:0] ren_valid;
  logic [W-1:0][LW-1:0] src1, src2, dst;
  logic ready;
  logic [W-1:0][PW-1:0] psrc1, psrc2, pdst, old_pdst;
  logic save, recover;
  logic [0:0] save_id, recover_id;
  logic [W-1:0] cmt_valid;
  logic [W-1:0][LW-1:0] cmt_dst;
  logic [W-1:0][PW-1:0] cmt_pdst, cmt_old;
  logic [NL-1:0][PW-1:0] arch_map;

  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  reg_rename i_reg_rename (
    .clk_i(clk), .rst_ni(rst_ni),
    .ren_valid_i(ren_valid), .ren_src1_i(src1), .ren_src2_i(src2), .ren_dst_i(dst),
    .ren_ready_o(ready), .ren_psrc1_o(psrc1), .ren_psrc2_o(psrc2),
    .ren_pdst_o(pdst), .ren_old_pdst_o(old_pdst),
    .ckpt_save_i(save), .ckpt_save_id_i(save_id),
    .recover_i(recover), .recover_id_i(recover_id),
    .cmt_valid_i(cmt_valid), .cmt_dst_i(cmt_dst), .cmt_pdst_i(cmt_pdst),
    .cmt_old_pdst_i(cmt_old), .arch_map_o(arch_map)
  );

  typedef struct packed {
    logic [1:0] v;
    logic [2:0] a1, a2, ad, b1, b2, bd;
    logic rdy, chk;
    logic [3:0] pa1, pa2, pda, opa, pb1, pb2, pdb, opb;
  } vec_t;

  // groups from reset, pool 6,7,8,9
  localparam vec_t VECS [3] = '{
    '{2'b11, 3'd1, 3'd2, 3'd1, 3'd1, 3'd3, 3'd2, 1'b1, 1'b1,
      4'd1, 4'd2, 4'd6, 4'd1, 4'd6, 4'd3, 4'd7, 4'd2},
    '{2'b11, 3'd2, 3'd1, 3'd1, 3'd1, 3'd4, 3'd1, 1'b1, 1'b1,
      4'd7, 4'd6, 4'd8, 4'd6, 4'd8, 4'd4, 4'd9, 4'd8},
    '{2'b01, 3'd0, 3'd5, 3'd3, 3'd0, 3'd0, 3'd0, 1'b0, 1'b0,
      4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0}
  };

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    ren_valid = '0; src1 = '0; src2 = '0; dst = '0;
    save = 1'b0; save_id = '0; recover = 1'b0; recover_id = '0;
    cmt_valid = '0; cmt_dst = '0; cmt_pdst = '0; cmt_old = '0;
  endtask

  task automatic set_ren(logic [1:0] v, int a1, int a2, int ad, int b1, int b2, int bd);
    ren_valid = v;
    src1[0] = LW'(a1); src2[0] = LW'(a2); dst[0] = LW'(ad);
    src1[1] = LW'(b1); src2[1] = LW'(b2); dst[1] = LW'(bd);
  endtask

  task automatic exp_slot(string req, int j, int p1, int p2, int pd, int op);
    check({req, " psrc1"}, int'(psrc1[j]), p1);
    check({req, " psrc2"}, int'(psrc2[j]), p2);
    check({req, " pdst"}, int'(pdst[j]), pd);
    check({req, " old_pdst"}, int'(old_pdst[j]), op);
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // R1 reset state of committed map
    for (int i = 0; i < NL; i++) check("R1 arch identity", int'(arch_map[i]), i);

    // table walk: R2 R3 R4 R5 R6
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      idle();
      set_ren(VECS[n].v, VECS[n].a1, VECS[n].a2, VECS[n].ad,
              VECS[n].b1, VECS[n].b2, VECS[n].bd);
      #1;
      check("R6 ready", int'(ready), int'(VECS[n].rdy));
      if (VECS[n].chk) begin
        exp_slot("R2/R3 slot0", 0, VECS[n].pa1, VECS[n].pa2, VECS[n].pda, VECS[n].opa);
        exp_slot("R4/R5 slot1", 1, VECS[n].pb1, VECS[n].pb2, VECS[n].pdb, VECS[n].opb);
      end
    end

    // R8 retire first group, frees 1 then 2
    @(negedge clk);
    idle();
    cmt_valid = 2'b11;
    cmt_dst[0] = 3'd1; cmt_pdst[0] = 4'd6; cmt_old[0] = 4'd1;
    cmt_dst[1] = 3'd2; cmt_pdst[1] = 4'd7; cmt_old[1] = 4'd2;
    @(negedge clk);
    idle();
    #1;
    check("R7 arch[1]", int'(arch_map[1]), 6);
    check("R7 arch[2]", int'(arch_map[2]), 7);
    check("R7 arch[0] kept", int'(arch_map[0]), 0);
    // slot 1 alone takes pool head
    set_ren(2'b10, 0, 0, 0, 3, 1, 4);
    #1;
    check("R6 ready one needed", int'(ready), 1);
    exp_slot("R8 freed reg reused", 1, 3, 9, 1, 4);

    // R6 one free, two needed
    @(negedge clk);
    idle();
    set_ren(2'b11, 0, 0, 5, 0, 0, 3);
    #1;
    check("R6 stall one short", int'(ready), 0);

    // R9 save checkpoint 0 with this group
    @(negedge clk);
    idle();
    set_ren(2'b01, 0, 0, 5, 0, 0, 0);
    save = 1'b1; save_id = 1'b0;
    #1;
    check("R6 ready after stall", int'(ready), 1);
    exp_slot("R6 stall left state", 0, 0, 0, 2, 5);

    // R7 both retire slots write logical 1
    @(negedge clk);
    idle();
    cmt_valid = 2'b11;
    cmt_dst[0] = 3'd1; cmt_pdst[0] = 4'd8; cmt_old[0] = 4'd6;
    cmt_dst[1] = 3'd1; cmt_pdst[1] = 4'd9; cmt_old[1] = 4'd8;
    @(negedge clk);
    idle();
    #1;
    check("R7 higher slot wins", int'(arch_map[1]), 9);
    set_ren(2'b11, 5, 5, 0, 0, 0, 3);
    #1;
    exp_slot("R8 pool order slot0", 0, 2, 2, 6, 0);
    exp_slot("R4 override slot1", 1, 6, 6, 8, 3);

    // R9 recovery cycle blocks rename
    @(negedge clk);
    idle();
    set_ren(2'b11, 0, 0, 1, 0, 0, 2);
    recover = 1'b1; recover_id = 1'b0;
    #1;
    check("R9 ready low on recover", int'(ready), 0);

    @(negedge clk);
    idle();
    set_ren(2'b11, 0, 3, 0, 5, 1, 4);
    #1;
    check("R9 ready after recover", int'(ready), 1);
    exp_slot("R9 restored map slot0", 0, 0, 3, 6, 0);
    exp_slot("R9 restored map slot1", 1, 2, 9, 8, 1);

    // pool now empty
    @(negedge clk);
    idle();
    set_ren(2'b01, 0, 0, 2, 0, 0, 0);
    #1;
    check("R6 stall empty pool", int'(ready), 0);

    @(negedge clk);
    idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule